// File: doc/BRIEF.md
# Three-Phase One-Wire LED Bit Encoder

This block turns pixel bytes into the pulse-width coded waveform that one-wire addressable LED strips expect. Every bit is a fixed-length period that starts high. A 0-bit drops low after the first phase, a 1-bit after the first two phases, and the period closes after the third phase. The three phase lengths are cycle counts on input pins, so one encoder serves chips with different timing. Conversion from nanoseconds to cycles is the job of whatever drives those pins.

With several lanes configured, one transfer on the input stream carries one byte per lane. Lane `l` takes byte `l` of `s_data`. All lanes walk one shared bit timeline, so every output rises on the same clock edge. After the last bit of a frame, the outputs stay low for a programmable latch gap, and `busy` covers that gap too.

The input stream is valid/ready. A transfer happens on a rising edge where `s_valid` and `s_ready` are both high. The encoder holds no buffer of its own. In mid-frame it raises `s_ready` for exactly one cycle, the last cycle of a group's final bit. The source must present valid data in that cycle, or the frame is aborted as an underrun. A source may hold `s_valid` high at any time without harm.

Top module: `nrz_encoder`

## Requirements
- R1: In reset and right after it, every `dout` lane is 0, `busy` is 0 and `underrun` is 0.
- R2: Every bit period starts with the lane high. For a 0-bit the lane stays high for exactly T1 cycles.
- R3: For a 1-bit the lane stays high for exactly T1+T2 cycles.
- R4: Each bit period lasts exactly T1+T2+T3 cycles for either bit value. The next bit rises at once, with no extra gap, across byte boundaries too.
- R5: Bits leave most-significant first and groups leave in arrival order. Lane `l` takes `s_data[8l+7:8l]`, and every lane rises on the same cycle.
- R6: A value of 0 on `t1_cyc`, `t2_cyc`, `t3_cyc` or `gap_cyc` is used as 1.
- R7: The timing inputs and `gap_cyc` are sampled only when a frame starts. Changing them while `busy` is high does not alter the frame in flight.
- R8: `busy` rises on the cycle after the first group is accepted and stays high for N*8*(T1+T2+T3) + G cycles, where G is the gap count. During the last G of those cycles, and whenever `busy` is low, every lane is low.
- R9: `s_ready` is high when idle with a nonzero `frame_len`. While sending, it is high only in the last cycle of a group's final bit when more groups remain. It is never high during the gap.
- R10: If no valid data is present in that ready cycle, the lanes go low at once, `underrun` becomes 1 and stays 1, and the gap runs. `underrun` clears when the next frame starts.
- R11: With `frame_len` equal to 0, no transfer is taken and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t1_cyc | input | TW | Phase 1 length in cycles |
| t2_cyc | input | TW | Phase 2 length in cycles |
| t3_cyc | input | TW | Phase 3 length in cycles |
| gap_cyc | input | GAP_W | Latch gap length in cycles |
| frame_len | input | LEN_W | Number of byte groups in the frame |
| s_valid | input | 1 | Input group valid |
| s_ready | output | 1 | Encoder ready for a group |
| s_data | input | 8*LANES | One byte per lane |
| dout | output | LANES | Serial lane outputs |
| busy | output | 1 | Frame or gap in progress |
| underrun | output | 1 | Sticky mid-frame starvation flag |

## Verification
The bench measures the high time and rise spacing of every bit on every lane. A design that picked the wrong threshold, sent bits LSB first, or put a stall cycle between bytes would show a wrong high width or a rise spacing that is off. The smallest timing (all phases 1) and zero-valued inputs check the clamp. Without the clamp, a zero phase would collapse a bit or make a period wrap. The bench changes the timing pins in mid-frame to catch a design that samples them live. It also starves the stream, which catches a design that stalls high, misses the sticky flag, or never clears it. A zero-length request checks that no byte is taken.

// File: rtl/nrz_pkg.sv
package nrz_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} nrz_state_e;

  function automatic logic [7:0] at_least_one8(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction
endpackage

// File: rtl/nrz_bit_timer.sv
module nrz_bit_timer #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic [PW-1:0] cnt,
  output logic          wrap
);
  assign wrap = run && (cnt == period - PW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + PW'(1);
  end
endmodule

// File: rtl/nrz_plane_shifter.sv
module nrz_plane_shifter #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               shift,
  input  logic [8*LANES-1:0] group,
  output logic [LANES-1:0]   plane
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (load)  sr <= group[8*l +: 8];
      else if (shift) sr <= {sr[6:0], 1'b0};
    end
    assign plane[l] = sr[7];
  end
endmodule

// File: rtl/nrz_encoder.sv
module nrz_encoder
  import nrz_pkg::*;
#(
  parameter int LANES = 2,
  parameter int TW    = 8,
  parameter int LEN_W = 8,
  parameter int GAP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TW-1:0]      t1_cyc,
  input  logic [TW-1:0]      t2_cyc,
  input  logic [TW-1:0]      t3_cyc,
  input  logic [GAP_W-1:0]   gap_cyc,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [8*LANES-1:0] s_data,
  output logic [LANES-1:0]   dout,
  output logic               busy,
  output logic               underrun
);
  localparam int PW = TW + 2;

  nrz_state_e       state;
  logic [TW-1:0]    t1_q, t2_q, t3_q;
  logic [GAP_W-1:0] gap_q, gcnt;
  logic [LEN_W-1:0] remain_q;
  logic [2:0]       bit_q;
  logic             err_q;

  logic [PW-1:0] thr0, thr1, period, cnt;
  logic          wrap, start, last_bit, need_more, load, shift;
  logic [LANES-1:0] plane;

  function automatic logic [TW-1:0] clamp_t(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  assign thr0   = PW'(t1_q);
  assign thr1   = PW'(t1_q) + PW'(t2_q);
  assign period = thr1 + PW'(t3_q);

  assign start     = (state == ST_IDLE) && s_valid && (frame_len != '0);
  assign last_bit  = (state == ST_SEND) && wrap && (bit_q == 3'd0);
  assign need_more = last_bit && (remain_q != '0);
  assign load      = start || (need_more && s_valid);
  assign shift     = (state == ST_SEND) && wrap && (bit_q != 3'd0);

  assign s_ready  = ((state == ST_IDLE) && (frame_len != '0)) || need_more;
  assign busy     = (state != ST_IDLE);
  assign underrun = err_q;

  nrz_bit_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_SEND),
    .period(period), .cnt(cnt), .wrap(wrap)
  );

  nrz_plane_shifter #(.LANES(LANES)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .group(s_data), .plane(plane)
  );

  // One shared timeline; each lane only picks its low edge.
  for (genvar l = 0; l < LANES; l++) begin : g_out
    assign dout[l] = (state == ST_SEND) && (cnt < (plane[l] ? thr1 : thr0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      t1_q     <= TW'(1);
      t2_q     <= TW'(1);
      t3_q     <= TW'(1);
      gap_q    <= GAP_W'(1);
      gcnt     <= '0;
      remain_q <= '0;
      bit_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          t1_q     <= clamp_t(t1_cyc);
          t2_q     <= clamp_t(t2_cyc);
          t3_q     <= clamp_t(t3_cyc);
          gap_q    <= (gap_cyc == '0) ? GAP_W'(1) : gap_cyc;
          remain_q <= frame_len - LEN_W'(1);
          bit_q    <= 3'd7;
          err_q    <= 1'b0;
          state    <= ST_SEND;
        end
        ST_SEND: if (wrap) begin
          if (bit_q != 3'd0) begin
            bit_q <= bit_q - 3'd1;
          end else if (remain_q != '0) begin
            if (s_valid) begin
              remain_q <= remain_q - LEN_W'(1);
              bit_q    <= 3'd7;
            end else begin
              err_q <= 1'b1;
              gcnt  <= '0;
              state <= ST_GAP;
            end
          end else begin
            gcnt  <= '0;
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gcnt >= gap_q - GAP_W'(1)) state <= ST_IDLE;
          else                           gcnt  <= gcnt + GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nrz_encoder_chk.sv
module nrz_encoder_chk #(
  parameter int LANES = 2,
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             busy,
  input logic             underrun,
  input logic [LANES-1:0] dout,
  input logic [LEN_W-1:0] frame_len
);
  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dout == '0));

  // R2
  frame_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dout == '1));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !(s_valid && s_ready && !busy)) |=> underrun);

  // R10
  err_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (dout == '0));

  // R11
  ready_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && s_ready) |-> (frame_len != '0));
endmodule

bind nrz_encoder nrz_encoder_chk #(.LANES(LANES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .busy(busy), .underrun(underrun), .dout(dout), .frame_len(frame_len)
);

// File: tb/sim_nrz_encoder.sv
module sim_nrz_encoder;
  localparam int LANES = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        t1_cyc = 8'd3, t2_cyc = 8'd4, t3_cyc = 8'd5;
  logic [15:0]       gap_cyc = 16'd20;
  logic [7:0]        frame_len = 8'd0;
  logic              s_valid = 1'b0;
  logic              s_ready;
  logic [8*LANES-1:0] s_data = '0;
  logic [LANES-1:0]  dout;
  logic              busy, underrun;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  nrz_encoder #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .t1_cyc(t1_cyc), .t2_cyc(t2_cyc),
    .t3_cyc(t3_cyc), .gap_cyc(gap_cyc), .frame_len(frame_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .dout(dout), .busy(busy), .underrun(underrun)
  );

  // Monitor: edge times per lane, sampled at falling clock edges.
  int cyc = 0;
  int rise_t [LANES][64];
  int hi_w   [LANES][64];
  int n_rise [LANES];
  int n_fall [LANES];
  int busy_cnt = 0;
  int rdy_late = 0;
  logic feeding_done = 1'b0;
  logic [LANES-1:0] prev = '0;
  logic [8*LANES-1:0] fdata [8];

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (busy && feeding_done && s_ready) rdy_late++;
    for (int l = 0; l < LANES; l++) begin
      if (dout[l] && !prev[l] && n_rise[l] < 64) begin
        rise_t[l][n_rise[l]] = cyc;
        n_rise[l]++;
      end
      if (!dout[l] && prev[l] && n_fall[l] < 64) begin
        hi_w[l][n_fall[l]] = cyc - rise_t[l][n_fall[l]];
        n_fall[l]++;
      end
    end
    prev = dout;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cl1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // Sends n_feed of n_groups groups from fdata; optionally disturbs timing pins mid-frame.
  task automatic run_frame(input int n_groups, input int n_feed,
                           input int a, input int b, input int c, input int g,
                           input logic disturb, input string tag);
    int e1, e2, e3, eg, per;
    e1 = cl1(a); e2 = cl1(b); e3 = cl1(c); eg = cl1(g);
    per = e1 + e2 + e3;
    @(negedge clk);
    t1_cyc = 8'(a); t2_cyc = 8'(b); t3_cyc = 8'(c); gap_cyc = 16'(g);
    frame_len = 8'(n_groups);
    for (int l = 0; l < LANES; l++) begin n_rise[l] = 0; n_fall[l] = 0; end
    busy_cnt = 0; rdy_late = 0; feeding_done = 1'b0;
    for (int k = 0; k < n_feed; k++) begin
      s_valid = 1'b1;
      s_data  = fdata[k];
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      if (k == 0) chk(underrun == 1'b0, {tag, " R10 flag cleared at start"}, int'(underrun), 0);
      if (disturb && k == 0) begin
        t1_cyc = 8'd9; t2_cyc = 8'd9; t3_cyc = 8'd9; gap_cyc = 16'd99;
      end
    end
    s_valid = 1'b0;
    feeding_done = (n_feed == n_groups);
    while (busy) @(negedge clk);
    @(negedge clk);
    feeding_done = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      chk(n_rise[l] == 8 * n_feed, {tag, " R5 bit count"}, n_rise[l], 8 * n_feed);
      for (int i = 0; i < 8 * n_feed && i < 64; i++) begin
        logic bv;
        bv = fdata[i / 8][8 * l + 7 - (i % 8)];
        if (bv) chk(hi_w[l][i] == e1 + e2, {tag, " R3 one-bit high"}, hi_w[l][i], e1 + e2);
        else    chk(hi_w[l][i] == e1, {tag, " R2 zero-bit high"}, hi_w[l][i], e1);
        if (i > 0)
          chk(rise_t[l][i] - rise_t[l][i-1] == per, {tag, " R4 period"},
              rise_t[l][i] - rise_t[l][i-1], per);
        chk(rise_t[l][i] == rise_t[0][i], {tag, " R5 lane lockstep"}, rise_t[l][i], rise_t[0][i]);
      end
    end
    chk(busy_cnt == n_feed * 8 * per + eg, {tag, " R8 busy length"}, busy_cnt, n_feed * 8 * per + eg);
    chk(underrun == (n_feed < n_groups), {tag, " R10 underrun flag"}, int'(underrun), int'(n_feed < n_groups));
    chk(dout == '0, {tag, " R8 lanes low after frame"}, int'(dout), 0);
    if (n_feed == n_groups) chk(rdy_late == 0, {tag, " R9 no ready after last group"}, rdy_late, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(dout == '0 && !busy && !underrun, "R1 in reset", int'({dout, busy, underrun}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dout == '0 && !busy && !underrun, "R1 after reset", int'({dout, busy, underrun}), 0);
  endtask

  task automatic t_basic();
    fdata[0] = 16'hA53C; fdata[1] = 16'h0FF0; fdata[2] = 16'h8001;
    run_frame(3, 3, 3, 4, 5, 20, 1'b0, "basic");
  endtask

  task automatic t_minimum();
    fdata[0] = 16'hFF00; fdata[1] = 16'h55AA;
    run_frame(2, 2, 1, 1, 1, 1, 1'b0, "min");
  endtask

  task automatic t_zero_clamp();
    // R6: zeros become 1, so phases are 1,2,1 and gap 1
    fdata[0] = 16'h6D92;
    run_frame(1, 1, 0, 2, 0, 0, 1'b0, "R6 clamp");
  endtask

  task automatic t_disturb();
    // R7: pins change after the first group is taken
    fdata[0] = 16'hC3A1; fdata[1] = 16'h3E7F;
    run_frame(2, 2, 2, 3, 2, 7, 1'b1, "R7 live change");
  endtask

  task automatic t_underrun();
    fdata[0] = 16'hB4E1;
    run_frame(3, 1, 2, 2, 2, 5, 1'b0, "R10 starve");
    fdata[0] = 16'h1234;
    run_frame(1, 1, 2, 2, 2, 5, 1'b0, "R10 recover");
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    frame_len = 8'd0; s_valid = 1'b1; s_data = 16'hFFFF;
    #1;
    chk(s_ready == 1'b0, "R9 no ready for empty frame", int'(s_ready), 0);
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && dout == '0, "R11 stays idle", int'({busy, dout}), 0);
    s_valid = 1'b0;
    #1;
    frame_len = 8'd1;
    #1;
    chk(s_ready == 1'b1, "R9 ready when idle", int'(s_ready), 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_minimum();
    t_zero_clamp();
    t_disturb();
    t_underrun();
    t_zero_len();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule